// File: doc/BRIEF.md
# Vector-Table Interrupt Capability Register Window

This block holds the configuration-space capability structure that advertises and controls a table-based message interrupt scheme. It occupies a window of three dwords. The first dword carries a fixed identifier byte, a link byte that points to the next capability, and a 16-bit control word. The control word reports the table size and holds two host-writable bits: a function-wide enable and a function-wide mask. The second and third dwords locate the vector table and the pending-bit array inside a memory window that a base-address register selects.

Configuration accesses arrive one dword at a time, with byte enables. Each enabled byte lands on its own offset and is filtered by a per-byte writable mask, so only the enable and mask bits ever change. The enable and mask are exported to the vector controller.

When a write lifts a condition that was holding deliveries back, the block raises a one-cycle rescan pulse. This happens when the mask drops from 1 to 0 or when the enable rises from 0 to 1. The controller then replays any vectors that are still pending.

Top module: `cap_window`

## Requirements
- R1: A synchronous active-low reset clears the enable bit, the mask bit, the rescan pulse and the read data register.
- R2: Dword 0 reads as follows: bits 7:0 hold the CAP_ID parameter, bits 15:8 hold the NEXT_PTR parameter, bits 26:16 hold NUM_VEC-1, bits 29:27 are zero, bit 30 is the mask and bit 31 is the enable.
- R3: Writes to bytes 0, 1 and 2 of dword 0, and to bits 29:24, have no effect.
- R4: A write to dword 0 with byte-enable bit 3 set loads the mask from data bit 30 and the enable from data bit 31. Without that byte enable, both bits hold their values.
- R5: Dword 1, the table locator, reads as BAR_IDX in bits 2:0 with all other bits zero (table offset 0). It is read-only.
- R6: Dword 2, the pending-array locator, reads as NUM_VEC*16 ORed with BAR_IDX in bits 2:0. It is read-only.
- R7: A write that takes the mask from 1 to 0 raises rescan for exactly the one cycle after the write edge.
- R8: A write that takes the enable from 0 to 1 raises rescan for exactly the one cycle after the write edge.
- R9: A write that causes both transitions at once produces a single one-cycle rescan pulse.
- R10: No other write raises rescan: setting the mask, clearing the enable, leaving both unchanged, or any write to dwords 1 to 3.
- R11: Dword 3 lies outside the capability. It reads as zero and writes to it are ignored.
- R12: Read data is registered. It updates on the clock edge that samples rd_en and holds its value while rd_en is low.
- R13: func_enable and func_mask show newly written values right after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Configuration write strobe |
| rd_en | input | 1 | Configuration read strobe |
| addr | input | 2 | Dword index within the window |
| be | input | 4 | Byte enables for the write |
| wdata | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| func_enable | output | 1 | Function-wide interrupt enable |
| func_mask | output | 1 | Function-wide interrupt mask |
| rescan | output | 1 | One-cycle request to replay pending vectors |

## Verification
The main sweep starts from each of the four enable/mask states. From each state it writes every one of the four new enable/mask values under all sixteen byte-enable patterns. This separates byte-3 gating from the other lanes, and separates the two pulse-raising transitions from the non-raising ones and from their coincidence. After each write, a readback of dword 0 shows whether any read-only field moved. A second sweep writes all-ones and all-zeros patterns to dwords 1 to 3 under every byte-enable pattern. It confirms that the locator dwords stay constant and that such writes neither touch the control bits nor raise rescan.

// File: rtl/cap_pkg.sv
// Package: shared constants and helper functions for the capability window.
// Assumes dword-granular accesses with a 2-bit dword index.
package cap_pkg;
    localparam int DW_BITS      = 32;
    localparam int ENTRY_BYTES  = 16;
    localparam int SIZE_BITS    = 11;
    localparam int MASK_BIT     = 14;
    localparam int EN_BIT       = 15;

    typedef enum logic [1:0] {
        DW_HEAD  = 2'd0,
        DW_TABLE = 2'd1,
        DW_PEND  = 2'd2,
        DW_OUT   = 2'd3
    } dw_sel_e;

    // Locator dword: byte offset with the BAR index placed in bits 2:0.
    function automatic logic [DW_BITS-1:0] locator(input int unsigned offs,
                                                   input int unsigned bar);
        logic [DW_BITS-1:0] v;
        v = DW_BITS'(offs);
        v[2:0] = 3'(bar);
        return v;
    endfunction
endpackage

// File: rtl/cap_msgctl.sv
// Module: holds the host-writable enable and mask bits of the control word
// and produces the rescan pulse when a write lifts a delivery block.
// Assumes hi_wr is already qualified to byte 3 of dword 0.
module cap_msgctl
    import cap_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hi_wr,
    input  logic [7:0] hi_byte,
    output logic       en_q,
    output logic       mask_q,
    output logic       rescan_q
);
    logic en_d, mask_d, lift;

    // Next-state for the two writable bits; the other six bits of the byte are dropped.
    always_comb begin
        en_d   = hi_wr ? hi_byte[EN_BIT-8]   : en_q;
        mask_d = hi_wr ? hi_byte[MASK_BIT-8] : mask_q;
        lift   = hi_wr && ((mask_q && !mask_d) || (!en_q && en_d));
    end

    // Register the bits and a single pulse for the write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q     <= 1'b0;
            mask_q   <= 1'b0;
            rescan_q <= 1'b0;
        end else begin
            en_q     <= en_d;
            mask_q   <= mask_d;
            rescan_q <= lift;
        end
    end

    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (!en_q && !mask_q && !rescan_q));
    a_r4_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
        !hi_wr |=> ($stable(en_q) && $stable(mask_q)));
    a_r10_rescan_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        rescan_q |-> $past(hi_wr));
    a_r9_one_cycle_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (rescan_q && !hi_wr) |=> !rescan_q);
    a_r7_unmask_pulses: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_wr && mask_q && !hi_byte[MASK_BIT-8]) |=> rescan_q);
    a_r8_enable_pulses: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_wr && !en_q && hi_byte[EN_BIT-8]) |=> rescan_q);
endmodule

// File: rtl/cap_readmux.sv
// Module: assembles the read image of the three capability dwords and
// registers the selected dword. Assumes addr 3 is outside the capability.
module cap_readmux
    import cap_pkg::*;
#(
    parameter logic [7:0] CAP_ID   = 8'h11,
    parameter logic [7:0] NEXT_PTR = 8'h40,
    parameter int         NUM_VEC  = 8,
    parameter int         BAR_IDX  = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rd_en,
    input  logic [1:0]         addr,
    input  logic               en_q,
    input  logic               mask_q,
    output logic [DW_BITS-1:0] rd_data
);
    localparam logic [SIZE_BITS-1:0] SIZE_FIELD = SIZE_BITS'(NUM_VEC - 1);
    localparam logic [DW_BITS-1:0]   TABLE_DW   = locator(0, BAR_IDX);
    localparam logic [DW_BITS-1:0]   PEND_DW    = locator(NUM_VEC * ENTRY_BYTES, BAR_IDX);

    logic [15:0]        ctl_word;
    logic [DW_BITS-1:0] sel;

    // Build the control word and pick the addressed dword.
    always_comb begin
        ctl_word = {en_q, mask_q, 3'b000, SIZE_FIELD};
        unique case (dw_sel_e'(addr))
            DW_HEAD:  sel = {ctl_word, NEXT_PTR, CAP_ID};
            DW_TABLE: sel = TABLE_DW;
            DW_PEND:  sel = PEND_DW;
            default:  sel = '0;
        endcase
    end

    // Capture the read on the sampling edge; hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= sel;
    end

    a_r12_read_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));
    a_r11_outside_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == 2'd3) |=> (rd_data == '0));
    a_r2_head_tracks_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == 2'd0) |=> (rd_data[31] == $past(en_q) && rd_data[30] == $past(mask_q)));
endmodule

// File: rtl/cap_window.sv
// Module: top of the capability register window. Decodes dword writes per
// byte lane; only lane 3 of dword 0 reaches writable state.
// Assumes 1 <= NUM_VEC <= 2048 and 0 <= BAR_IDX <= 5 (checked at elaboration).
module cap_window
    import cap_pkg::*;
#(
    parameter logic [7:0] CAP_ID   = 8'h11,
    parameter logic [7:0] NEXT_PTR = 8'h40,
    parameter int         NUM_VEC  = 8,
    parameter int         BAR_IDX  = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic        rd_en,
    input  logic [1:0]  addr,
    input  logic [3:0]  be,
    input  logic [31:0] wdata,
    output logic [31:0] rd_data,
    output logic        func_enable,
    output logic        func_mask,
    output logic        rescan
);
    localparam int LANES = DW_BITS / 8;

    if (NUM_VEC < 1 || NUM_VEC > 2048) begin : g_bad_vec
        $error("NUM_VEC out of range");
    end
    if (BAR_IDX < 0 || BAR_IDX > 5) begin : g_bad_bar
        $error("BAR_IDX out of range");
    end

    logic [LANES-1:0] lane_wr;
    logic [7:0]       lane_byte [LANES];

    // Per-lane write strobes and data, one byte per consecutive offset.
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign lane_wr[i]   = wr_en && be[i] && (dw_sel_e'(addr) == DW_HEAD);
        assign lane_byte[i] = wdata[8*i +: 8];
    end

    cap_msgctl u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .hi_wr    (lane_wr[3]),
        .hi_byte  (lane_byte[3]),
        .en_q     (func_enable),
        .mask_q   (func_mask),
        .rescan_q (rescan)
    );

    cap_readmux #(
        .CAP_ID   (CAP_ID),
        .NEXT_PTR (NEXT_PTR),
        .NUM_VEC  (NUM_VEC),
        .BAR_IDX  (BAR_IDX)
    ) u_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en   (rd_en),
        .addr    (addr),
        .en_q    (func_enable),
        .mask_q  (func_mask),
        .rd_data (rd_data)
    );

    a_r11_outside_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr != 2'd0) |=> ($stable(func_enable) && $stable(func_mask) && !rescan));
endmodule

// File: tb/sim_cap_window.sv
// Bench: exhaustive sweep of state x new value x byte-enable pattern.
module sim_cap_window;
    localparam logic [7:0] CID = 8'h11;
    localparam logic [7:0] NXT = 8'h40;
    localparam int         NV  = 8;
    localparam int         BAR = 3;

    logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0;
    logic [1:0] addr = 0;
    logic [3:0] be = 0;
    logic [31:0] wdata = 0, rd_data;
    logic func_enable, func_mask, rescan;
    int checks = 0, errors = 0;
    logic r_after, r_next, e_after, m_after;

    always #5 clk = ~clk;

    cap_window #(.CAP_ID(CID), .NEXT_PTR(NXT), .NUM_VEC(NV), .BAR_IDX(BAR)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .be(be), .wdata(wdata), .rd_data(rd_data), .func_enable(func_enable),
        .func_mask(func_mask), .rescan(rescan));

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] head(input logic e, input logic m);
        return {e, m, 3'b000, 11'(NV - 1), NXT, CID};
    endfunction

    // Called at a negedge; captures outputs after the write edge and the one after.
    task automatic wr(input logic [1:0] a, input logic [3:0] b, input logic [31:0] d);
        wr_en = 1; addr = a; be = b; wdata = d;
        @(posedge clk); #1;
        r_after = rescan; e_after = func_enable; m_after = func_mask;
        @(negedge clk); wr_en = 0;
        @(posedge clk); #1;
        r_next = rescan;
        @(negedge clk);
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] v);
        rd_en = 1; addr = a;
        @(posedge clk); #1; v = rd_data;
        @(negedge clk); rd_en = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] v, hold;
        logic exp_e, exp_m, exp_r;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 enable", {31'b0, func_enable}, 0);
        chk("R1 mask", {31'b0, func_mask}, 0);
        chk("R1 rescan", {31'b0, rescan}, 0);
        chk("R1 rd_data", rd_data, 0);
        rst_n = 1;
        @(negedge clk);
        rd(2'd0, v); chk("R2 head after reset", v, head(0, 0));
        rd(2'd1, v); chk("R5 table locator", v, 32'(BAR));
        rd(2'd2, v); chk("R6 pending locator", v, 32'(NV * 16) | 32'(BAR));
        rd(2'd3, v); chk("R11 outside read", v, 0);
        // R12: read data holds with rd_en low
        rd(2'd1, hold);
        repeat (3) @(negedge clk);
        chk("R12 hold", rd_data, hold);

        // Main sweep: old state x new value x byte enables.
        for (int os = 0; os < 4; os++) begin
            for (int ns = 0; ns < 4; ns++) begin
                for (int b = 0; b < 16; b++) begin
                    logic oe, om, ne, nm;
                    oe = os[1]; om = os[0]; ne = ns[1]; nm = ns[0];
                    wr(2'd0, 4'b1000, {oe, om, 30'h0});
                    wr(2'd0, 4'(b), {ne, nm, 30'h3A5C_96F1 ^ 30'(b * 7)});
                    exp_e = b[3] ? ne : oe;
                    exp_m = b[3] ? nm : om;
                    exp_r = b[3] && ((om && !nm) || (!oe && ne));
                    chk("R4/R13 enable", {31'b0, e_after}, {31'b0, exp_e});
                    chk("R4/R13 mask", {31'b0, m_after}, {31'b0, exp_m});
                    chk("R7/R8/R10 rescan", {31'b0, r_after}, {31'b0, exp_r});
                    chk("R9 pulse width", {31'b0, r_next}, 0);
                    rd(2'd0, v);
                    chk("R2/R3 head readback", v, head(exp_e, exp_m));
                end
            end
        end

        // R9: both transitions together give one pulse.
        wr(2'd0, 4'b1000, 32'h4000_0000);
        wr(2'd0, 4'b1111, 32'h8000_0000);
        chk("R9 joint pulse", {30'b0, r_after, r_next}, 32'b10);

        // R5, R6, R11: writes outside the control lane.
        for (int a = 1; a < 4; a++) begin
            for (int b = 0; b < 16; b++) begin
                wr(2'd0, 4'b1000, 32'h4000_0000);
                wr(2'(a), 4'(b), (b % 2 == 0) ? 32'hFFFF_FFFF : 32'h0);
                chk("R10/R11 no pulse", {31'b0, r_after}, 0);
                chk("R11 bits kept", {30'b0, e_after, m_after}, 32'b01);
                rd(2'(a), v);
                chk("R5/R6/R11 readonly", v,
                    (a == 1) ? 32'(BAR) : (a == 2) ? (32'(NV * 16) | 32'(BAR)) : 32'h0);
            end
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule